// File: doc/BRIEF.md
# Receive Frame Address and Length Filter

This block sits on the receive byte stream of an Ethernet MAC, after preamble removal and before any buffering. It decides for each frame whether the frame is kept or discarded. The decision rests on four checks:

- whether the destination address equals the programmed station address;
- whether the frame is a group (multicast or broadcast) frame;
- whether the frame is a MAC control frame;
- whether its length lies inside the allowed window.

Each address and type check has its own discard enable, so software can build normal, promiscuous or mixed filtering from them. CRC checking, preamble handling and pause processing are left to other blocks.

A small state machine follows where each byte sits in the frame header. Its states are IDLE (no frame open), DEST (destination octets 1 to 5), SRC (octets 6 to 11), TYPE (octets 12 and 13) and BODY (everything after the header). Its transitions are:

- IDLE→DEST on a start marker.
- DEST→SRC after octet 5.
- SRC→TYPE after octet 11.
- TYPE→BODY after octet 13.
- Any state→IDLE on an end marker.
- Any state→DEST on a start marker, which restarts the frame.

The verdict, the length-error flag and the byte count are registered together and appear for one cycle after the end beat.

Top module: `rxf_filter`

## Requirements
- R1: After reset `dec_valid` is low, and it stays low until a frame has ended.
- R2: The byte carrying the end marker is sampled at a clock edge, and at that same edge `dec_valid` rises for one cycle. `dec_len` then equals the number of bytes from the start byte through the end byte inclusive. A frame of one byte, with start and end on the same beat, has a length of 1.
- R3: The station address octet k is the k-th destination byte on the wire.
  - Octets 0 to 3 sit in `cfg_station_lo`, with octet k at bits [8k+7:8k].
  - Octets 4 and 5 sit in `cfg_station_hi`, at bits [7:0] and [15:8].
  - With `cfg_drop_mismatch` set, a frame whose destination differs from the station address in any octet is dropped.
- R4: A frame is a group frame when bit 0 of its first destination byte is 1. Broadcast is included. With `cfg_drop_group` set, group frames are dropped.
- R5: With both address discard enables clear, every frame passes the address checks, whatever its destination.
- R6: The length limit is `cfg_mtu` + 18. When that sum exceeds the parameter `HW_CEIL`, the limit is `HW_CEIL` instead. A frame longer than the limit raises `dec_len_err` and is dropped. A frame exactly at the limit is not affected by this check.
- R7: A frame shorter than 60 bytes raises `dec_len_err` and is dropped. A 60-byte frame is not flagged.
- R8: A frame whose bytes 12 and 13 are 0x88 then 0x08 is a control frame. With `cfg_drop_ctrl` set it is dropped; with it clear it is delivered. Any other type value, for example 0x88 0x09, is not a control frame.
- R9: Two cases of stray input are handled without a verdict:
  - A start marker inside an open frame abandons that frame without a verdict and begins a new one.
  - Valid bytes outside a frame, including a stray end marker with no start, are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| cfg_station_lo | input | 32 | Station address octets 0..3 |
| cfg_station_hi | input | 16 | Station address octets 4..5 |
| cfg_mtu | input | LEN_W | Payload size used to form the length limit |
| cfg_drop_mismatch | input | 1 | Discard frames not addressed to the station |
| cfg_drop_group | input | 1 | Discard multicast and broadcast frames |
| cfg_drop_ctrl | input | 1 | Discard MAC control frames |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_len_err | output | 1 | Frame is too short or too long |
| dec_len | output | LEN_W | Byte count of the frame |

## Verification
Every combination of the three discard enables is applied to the same set of destination and type patterns:

- an exact station match;
- a single wrong octet at each of the six positions;
- a multicast address and the broadcast address;
- a control type, and a type that differs from it only in its last bit.

The single-octet cases show that each station octet is wired to the right wire position. The group and broadcast cases separate the group check from the mismatch check, and the near-control type shows that both type bytes are compared.

A length sweep crosses the 60-byte boundary and the programmed limit. A large payload size exercises the clipping of the limit to the ceiling. Aborted frames and stray bytes show that only a properly opened frame yields a verdict.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEST,
        ST_SRC,
        ST_TYPE,
        ST_BODY
    } rxf_state_e;

    localparam int MIN_FRAME    = 60;
    localparam int HDR_OVERHEAD = 18;
    localparam int DA_LAST      = 5;
    localparam int SA_LAST      = 11;
    localparam int TYPE_HI_POS  = 12;
    localparam int TYPE_LO_POS  = 13;
    localparam logic [7:0] CTRL_HI = 8'h88;
    localparam logic [7:0] CTRL_LO = 8'h08;
endpackage

// File: rtl/rxf_da_cmp.sv
module rxf_da_cmp (
    input  logic [2:0]  pos_i,
    input  logic        en_i,
    input  logic [7:0]  byte_i,
    input  logic [31:0] station_lo_i,
    input  logic [15:0] station_hi_i,
    output logic        differ_o,
    output logic        group_o
);
    logic [7:0] octet [6];

    genvar gi;
    generate
        for (gi = 0; gi < 4; gi++) begin : g_lo
            assign octet[gi] = station_lo_i[8*gi +: 8];
        end
        for (gi = 0; gi < 2; gi++) begin : g_hi
            assign octet[4+gi] = station_hi_i[8*gi +: 8];
        end
    endgenerate

    always_comb begin
        differ_o = 1'b0;
        group_o  = 1'b0;
        if (en_i && pos_i <= 3'd5) begin
            differ_o = (byte_i != octet[pos_i]);
            group_o  = (pos_i == 3'd0) && byte_i[0];
        end
    end
endmodule

// File: rtl/rxf_len_lim.sv
module rxf_len_lim #(
    parameter int LEN_W   = 12,
    parameter int HW_CEIL = 1536
) (
    input  logic [LEN_W-1:0] mtu_i,
    input  logic [LEN_W-1:0] count_i,
    output logic             runt_o,
    output logic             over_o
);
    import rxf_pkg::*;

    localparam logic [LEN_W:0] CEIL_W = (LEN_W+1)'(HW_CEIL);
    localparam logic [LEN_W:0] OVH_W  = (LEN_W+1)'(HDR_OVERHEAD);

    logic [LEN_W:0] sum_w;
    logic [LEN_W:0] limit_w;

    always_comb begin
        sum_w   = {1'b0, mtu_i} + OVH_W;
        limit_w = (sum_w > CEIL_W) ? CEIL_W : sum_w;
        over_o  = {1'b0, count_i} > limit_w;
        runt_o  = count_i < LEN_W'(MIN_FRAME);
    end
endmodule

// File: rtl/rxf_filter.sv
module rxf_filter #(
    parameter int LEN_W   = 12,
    parameter int HW_CEIL = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_byte,
    input  logic [31:0]      cfg_station_lo,
    input  logic [15:0]      cfg_station_hi,
    input  logic [LEN_W-1:0] cfg_mtu,
    input  logic             cfg_drop_mismatch,
    input  logic             cfg_drop_group,
    input  logic             cfg_drop_ctrl,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_len_err,
    output logic [LEN_W-1:0] dec_len
);
    import rxf_pkg::*;

    rxf_state_e state_q, state_d;

    logic [LEN_W-1:0] cnt_q;
    logic             mism_q, grp_q, thi_q, ctl_q;

    logic             start_w, take_w, end_w;
    logic [LEN_W-1:0] pos_w, cnt_next_w;
    logic             dest_w, differ_w, group_w;
    logic             mism_n, grp_n, thi_n, ctl_n;
    logic             runt_w, over_w, verdict_w;

    assign start_w = in_valid && in_sof;
    assign take_w  = start_w || (in_valid && state_q != ST_IDLE);
    assign end_w   = take_w && in_eof;
    assign pos_w   = start_w ? '0 : cnt_q;
    assign cnt_next_w = (&pos_w) ? pos_w : pos_w + 1'b1;
    assign dest_w  = start_w || (state_q == ST_DEST);

    rxf_da_cmp da_i (
        .pos_i        (pos_w[2:0]),
        .en_i         (dest_w),
        .byte_i       (in_byte),
        .station_lo_i (cfg_station_lo),
        .station_hi_i (cfg_station_hi),
        .differ_o     (differ_w),
        .group_o      (group_w)
    );

    rxf_len_lim #(.LEN_W(LEN_W), .HW_CEIL(HW_CEIL)) len_i (
        .mtu_i   (cfg_mtu),
        .count_i (cnt_next_w),
        .runt_o  (runt_w),
        .over_o  (over_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_w) begin
            state_d = in_eof ? ST_IDLE : ST_DEST;
        end else if (take_w && in_eof) begin
            state_d = ST_IDLE;
        end else if (take_w) begin
            unique case (state_q)
                ST_DEST: if (pos_w == LEN_W'(DA_LAST))     state_d = ST_SRC;
                ST_SRC:  if (pos_w == LEN_W'(SA_LAST))     state_d = ST_TYPE;
                ST_TYPE: if (pos_w == LEN_W'(TYPE_LO_POS)) state_d = ST_BODY;
                ST_BODY: state_d = ST_BODY;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // header flag update for the current byte
    always_comb begin
        mism_n = (start_w ? 1'b0 : mism_q) | differ_w;
        grp_n  = start_w ? group_w : grp_q;
        thi_n  = start_w ? 1'b0 : thi_q;
        ctl_n  = start_w ? 1'b0 : ctl_q;
        if (take_w && state_q == ST_TYPE) begin
            if (pos_w == LEN_W'(TYPE_HI_POS))
                thi_n = (in_byte == CTRL_HI);
            if (pos_w == LEN_W'(TYPE_LO_POS))
                ctl_n = thi_q && (in_byte == CTRL_LO);
        end
        verdict_w = !(runt_w || over_w)
                  && !(cfg_drop_mismatch && mism_n)
                  && !(cfg_drop_group    && grp_n)
                  && !(cfg_drop_ctrl     && ctl_n);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-frame working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mism_q <= 1'b0;
            grp_q  <= 1'b0;
            thi_q  <= 1'b0;
            ctl_q  <= 1'b0;
        end else if (take_w) begin
            cnt_q  <= cnt_next_w;
            mism_q <= mism_n;
            grp_q  <= grp_n;
            thi_q  <= thi_n;
            ctl_q  <= ctl_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            dec_accept  <= 1'b0;
            dec_len_err <= 1'b0;
            dec_len     <= '0;
        end else begin
            dec_valid <= end_w;
            if (end_w) begin
                dec_accept  <= verdict_w;
                dec_len_err <= runt_w || over_w;
                dec_len     <= cnt_next_w;
            end
        end
    end
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
    parameter int LEN_W   = 12,
    parameter int HW_CEIL = 1536
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_eof,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             dec_len_err,
    input logic [LEN_W-1:0] dec_len
);
    assert_dec_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid && in_eof));

    assert_runt_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_len < LEN_W'(60)) |-> (dec_len_err && !dec_accept));

    assert_ceiling_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_len > LEN_W'(HW_CEIL)) |-> (dec_len_err && !dec_accept));

    assert_accept_no_len_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_accept) |-> !dec_len_err);
endmodule

bind rxf_filter rxf_filter_chk #(.LEN_W(LEN_W), .HW_CEIL(HW_CEIL)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_eof      (in_eof),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept),
    .dec_len_err (dec_len_err),
    .dec_len     (dec_len)
);

// File: tb/rxf_filter_tb.sv
module rxf_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 12;
    localparam int HW_CEIL    = 1536;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]       in_byte = '0;
    logic [31:0]      cfg_station_lo = 32'h3322_1102;
    logic [15:0]      cfg_station_hi = 16'h5544;
    logic [LEN_W-1:0] cfg_mtu = LEN_W'(100);
    logic             cfg_drop_mismatch = 1'b0, cfg_drop_group = 1'b0, cfg_drop_ctrl = 1'b0;
    logic             dec_valid, dec_accept, dec_len_err;
    logic [LEN_W-1:0] dec_len;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] station [6] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};

    always #(CLK_PERIOD/2) clk = ~clk;

    rxf_filter #(.LEN_W(LEN_W), .HW_CEIL(HW_CEIL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_byte(in_byte), .cfg_station_lo(cfg_station_lo),
        .cfg_station_hi(cfg_station_hi), .cfg_mtu(cfg_mtu),
        .cfg_drop_mismatch(cfg_drop_mismatch), .cfg_drop_group(cfg_drop_group),
        .cfg_drop_ctrl(cfg_drop_ctrl), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_len_err(dec_len_err), .dec_len(dec_len)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // kind: 0 match, 1 one wrong octet, 2 multicast, 3 broadcast, 4 control, 5 near-control
    function automatic logic [7:0] frame_byte(int kind, int mpos, int i);
        logic [7:0] b;
        if (i < 6) begin
            b = station[i];
            if (kind == 1 && i == mpos) b = b ^ 8'h40;
            if (kind == 2 && i == 0)    b = b | 8'h01;
            if (kind == 3)              b = 8'hFF;
        end else if (i < 12) b = 8'hA0 + 8'(i);
        else if (i == 12)    b = (kind >= 4) ? 8'h88 : 8'h08;
        else if (i == 13)    b = (kind == 4) ? 8'h08 : ((kind == 5) ? 8'h09 : 8'h00);
        else                 b = 8'(i);
        return b;
    endfunction

    task automatic drive_bytes(int len, int kind, int mpos, bit close);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = close && (i == len - 1);
            in_byte  = frame_byte(kind, mpos, i);
        end
    endtask

    task automatic send_frame(int len, int kind, int mpos, string tag);
        bit mism, grp, ctl, lerr, acc;
        int lim;
        drive_bytes(len, kind, mpos, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        mism = (kind >= 1 && kind <= 3);
        grp  = (kind == 2 || kind == 3);
        ctl  = (kind == 4) && (len >= 14);
        lim  = int'(cfg_mtu) + 18;
        if (lim > HW_CEIL) lim = HW_CEIL;
        lerr = (len < 60) || (len > lim);
        acc  = !lerr && !(cfg_drop_mismatch && mism) && !(cfg_drop_group && grp)
               && !(cfg_drop_ctrl && ctl);
        check("R2 dec_valid", int'(dec_valid), 1);
        check("R2 dec_len", int'(dec_len), len);
        check({tag, " dec_accept"}, int'(dec_accept), int'(acc));
        check("R6/R7 dec_len_err", int'(dec_len_err), int'(lerr));
        @(negedge clk);
        check("R2 strobe one cycle", int'(dec_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset dec_valid", int'(dec_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle dec_valid", int'(dec_valid), 0);

        // enable combinations x address/type patterns
        for (int cfg = 0; cfg < 8; cfg++) begin
            cfg_drop_mismatch = cfg[0];
            cfg_drop_group    = cfg[1];
            cfg_drop_ctrl     = cfg[2];
            for (int kind = 0; kind < 6; kind++) begin
                for (int mp = 0; mp < ((kind == 1) ? 6 : 1); mp++) begin
                    string tag;
                    if (kind == 1)                  tag = "R3";
                    else if (kind == 2 || kind == 3) tag = "R4";
                    else if (kind >= 4)             tag = "R8";
                    else                            tag = "R5";
                    if (cfg[1:0] == 2'b00 && kind < 4) tag = "R5";
                    send_frame(64, kind, mp, tag);
                end
            end
        end

        // length sweep across runt boundary and programmed limit (mtu 100 -> 118)
        cfg_drop_mismatch = 1'b1; cfg_drop_group = 1'b1; cfg_drop_ctrl = 1'b1;
        for (int len = 1; len <= 130; len++) begin
            send_frame(len, 0, 0, (len < 100) ? "R7" : "R6");
        end

        // limit clipped to ceiling
        cfg_mtu = LEN_W'(2000);
        send_frame(HW_CEIL - 1, 0, 0, "R6");
        send_frame(HW_CEIL,     0, 0, "R6");
        send_frame(HW_CEIL + 1, 0, 0, "R6");
        cfg_mtu = LEN_W'(100);

        // abandoned frame then a new frame (R9)
        drive_bytes(30, 0, 0, 1'b0);
        check("R9 no verdict on abandon", int'(dec_valid), 0);
        send_frame(64, 1, 2, "R9");
        send_frame(70, 0, 0, "R9");

        // stray bytes outside any frame, including an end marker (R9)
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R9 stray ignored", int'(dec_valid), 0);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (i % 2 == 1); in_byte = 8'(i);
        end
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        check("R9 stray ignored", int'(dec_valid), 0);
        @(negedge clk);
        check("R9 stray ignored", int'(dec_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule